// File: doc/BRIEF.md
# Descriptor Chain Walker for Scatter-Gather DMA

This block sits in front of a DMA data mover and walks a linked list of transfer descriptors held in host memory. The host writes the address of the first descriptor into a pointer register, which starts the walk. The block reads each descriptor through a single-outstanding memory-read port. A descriptor is three consecutive 32-bit words, aligned to 16 bytes:

- offset 0: host buffer address
- offset 4: byte count
- offset 8: link word

For each descriptor with a non-zero count, the block issues one transfer command to the data mover. It then waits for the mover to report completion before it follows the link.

The link word carries two flags in its low bits:

- bit 0 set: this descriptor is the final one.
- bit 1: transfer direction. 1 means board to host memory; 0 means host memory to board.

The block clears the four low bits of the link word to form the next descriptor address. When the final descriptor finishes, a sticky done bit is latched. The host clears it by writing a one to that bit. An interrupt output reflects the done bit, gated by an interrupt enable and a master enable.

Top module: `sgl_walker`

## Requirements
- R1: A descriptor at base B is read as three requests, in order, at B, B+4 and B+8. Each request holds `mem_req` high with a stable `mem_addr` until `mem_ack`. Data is taken with the ack.
- R2: Each issued command carries:
  - `xfer_addr` = word 0;
  - `xfer_len` = the low LEN_W bits of word 1;
  - `xfer_to_host` = bit 1 of word 2 (1 = board to host memory, 0 = host memory to board).
- R3: The next descriptor base is the link word with bits 3..0 forced to zero. A link word with bit 0 set ends the chain after the current descriptor.
- R4: A descriptor whose full 32-bit count word is zero issues no command. The walk continues with its link, or ends if bit 0 is set.
- R5: A write to register index 0 while idle stores the pointer with bits 3..0 zeroed. The stored pointer reads back at index 0. The write starts fetching on the next cycle. Status bit 0 (busy) is high from the cycle after the write until the chain ends.
- R6: A write to register index 0 while busy is ignored. The stored pointer and the descriptors walked are unchanged.
- R7: Status bit 1 (done, register index 1) is set in the same cycle that busy falls. It stays set while writes carry a zero in bit 1, and is cleared by writing a one to bit 1.
- R8: `irq` = done AND control bit 0 (interrupt enable) AND control bit 1 (master enable). The control register is at index 2; index 3 reads zero.
- R9: `xfer_valid` and the command fields hold until `xfer_ready`. The next fetch waits for the `xfer_done` pulse of the accepted command.
- R10: After reset the following are all zero: busy, done, `irq`, control bits, `mem_req`, `xfer_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 pointer, 1 status, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid with it |
| mem_rdata | input | 32 | Read data |
| xfer_valid | output | 1 | Transfer command valid |
| xfer_ready | input | 1 | Mover accepts the command |
| xfer_addr | output | 32 | Host buffer address |
| xfer_len | output | LEN_W | Byte count |
| xfer_to_host | output | 1 | 1 = board to host memory, 0 = host memory to board |
| xfer_done | input | 1 | One-cycle pulse when the accepted transfer completes |
| irq | output | 1 | Gated completion interrupt |

## Verification
Timing of each result, counted from the clock edge that captures the stimulus:

- A pointer write is captured on one edge, and busy and `mem_req` are visible on the next sample after it.
- The done bit sets on the same edge where busy falls, either the edge that takes the last word of a zero-count final descriptor or the edge that takes the final `xfer_done`. `irq` follows combinationally in that same cycle.

The bench therefore polls status at falling edges and checks done at the very sample where busy is first seen low. It also reads the pointer back at once after the ignored write.

Commands and fetch addresses are logged at the falling edge before the accepting rising edge. The bench compares them with lists it builds from its own memory image, sweeping every direction pattern and every zero-count pattern for chains of one to three descriptors.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned ALIGN_LSB = 4;
  localparam int unsigned LAST_BIT  = 0;
  localparam int unsigned DIR_BIT   = 1;
  localparam int unsigned REG_IDX_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } walk_st_t;

  // Clear the flag/alignment bits of a link or pointer word.
  function automatic logic [WORD_W-1:0] strip_flags(input logic [WORD_W-1:0] w);
    return {w[WORD_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
  endfunction

  // Byte address of word idx within a descriptor at base.
  function automatic logic [WORD_W-1:0] word_addr(input logic [WORD_W-1:0] base,
                                                  input logic [1:0] idx);
    return base + {{(WORD_W-4){1'b0}}, idx, 2'b00};
  endfunction
endpackage

// File: rtl/sgl_walk_fsm.sv
module sgl_walk_fsm
  import sgl_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] start_ptr,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [WORD_W-1:0] xfer_addr,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              xfer_to_host,
  input  logic              xfer_done,
  output logic              busy,
  output logic              chain_end
);
  localparam logic [1:0] LAST_IDX = 2'd2;

  walk_st_t          state;
  logic [WORD_W-1:0] base;
  logic [1:0]        idx;
  logic [WORD_W-1:0] w_addr;
  logic [WORD_W-1:0] w_cnt;
  logic [WORD_W-1:0] w_link;

  // Named internal events for assertions.
  logic desc_loaded;
  logic skip_now;
  logic step_done;
  logic [WORD_W-1:0] cur_link;

  assign desc_loaded = (state == ST_FETCH) && mem_ack && (idx == LAST_IDX);
  assign skip_now    = desc_loaded && (w_cnt == '0);
  assign step_done   = skip_now || ((state == ST_WAIT) && xfer_done);
  assign cur_link    = (state == ST_FETCH) ? mem_rdata : w_link;
  assign chain_end   = step_done && cur_link[LAST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      base   <= '0;
      idx    <= '0;
      w_addr <= '0;
      w_cnt  <= '0;
      w_link <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            base  <= strip_flags(start_ptr);
            idx   <= '0;
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            case (idx)
              2'd0:    w_addr <= mem_rdata;
              2'd1:    w_cnt  <= mem_rdata;
              default: w_link <= mem_rdata;
            endcase
            idx <= idx + 2'd1;
            if (idx == LAST_IDX) begin
              if (w_cnt != '0) begin
                state <= ST_ISSUE;
              end else if (mem_rdata[LAST_BIT]) begin
                state <= ST_IDLE;
              end else begin
                base <= strip_flags(mem_rdata);
                idx  <= '0;
              end
            end
          end
        end
        ST_ISSUE: begin
          if (xfer_ready) state <= ST_WAIT;
        end
        default: begin
          if (xfer_done) begin
            if (w_link[LAST_BIT]) begin
              state <= ST_IDLE;
            end else begin
              base  <= strip_flags(w_link);
              idx   <= '0;
              state <= ST_FETCH;
            end
          end
        end
      endcase
    end
  end

  assign mem_req      = (state == ST_FETCH);
  assign mem_addr     = word_addr(base, idx);
  assign xfer_valid   = (state == ST_ISSUE);
  assign xfer_addr    = w_addr;
  assign xfer_len     = w_cnt[LEN_W-1:0];
  assign xfer_to_host = w_link[DIR_BIT];
  assign busy         = (state != ST_IDLE);

  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable({xfer_addr, xfer_len, xfer_to_host}));
  a_r9_no_fetch_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready |=> !mem_req);
  a_r4_no_zero_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_valid) |-> $past(w_cnt) != '0);
  a_r5_start_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> mem_req && busy);
  a_r3_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    chain_end |=> !busy);
endmodule

// File: rtl/sgl_status.sv
module sgl_status
  import sgl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic                 busy,
  input  logic                 chain_end,
  output logic                 start,
  output logic                 irq
);
  localparam logic [REG_IDX_W-1:0] IDX_PTR  = 2'd0;
  localparam logic [REG_IDX_W-1:0] IDX_STAT = 2'd1;
  localparam logic [REG_IDX_W-1:0] IDX_CTRL = 2'd2;

  logic [WORD_W-1:0] head;
  logic done, irq_en, master_en;
  logic clr_req;

  assign start   = reg_wr && (reg_addr == IDX_PTR) && !busy;
  assign clr_req = reg_wr && (reg_addr == IDX_STAT) && reg_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      done      <= 1'b0;
      irq_en    <= 1'b0;
      master_en <= 1'b0;
    end else begin
      if (start) head <= strip_flags(reg_wdata);
      if (chain_end)    done <= 1'b1;
      else if (clr_req) done <= 1'b0;
      if (reg_wr && (reg_addr == IDX_CTRL)) begin
        irq_en    <= reg_wdata[0];
        master_en <= reg_wdata[1];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      IDX_PTR:  reg_rdata = head;
      IDX_STAT: reg_rdata = {{(WORD_W-2){1'b0}}, done, busy};
      IDX_CTRL: reg_rdata = {{(WORD_W-2){1'b0}}, master_en, irq_en};
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = done && irq_en && master_en;

  a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    chain_end |=> done);
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr_req |=> done);
  a_r6_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == IDX_PTR) && busy |=> $stable(head));
  a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done);
endmodule

// File: rtl/sgl_walker.sv
module sgl_walker
  import sgl_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic                 mem_req,
  output logic [WORD_W-1:0]    mem_addr,
  input  logic                 mem_ack,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 xfer_valid,
  input  logic                 xfer_ready,
  output logic [WORD_W-1:0]    xfer_addr,
  output logic [LEN_W-1:0]     xfer_len,
  output logic                 xfer_to_host,
  input  logic                 xfer_done,
  output logic                 irq
);
  logic busy, chain_end, start;

  sgl_status u_status (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .chain_end(chain_end), .start(start), .irq(irq)
  );

  sgl_walk_fsm #(.LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(reg_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_to_host(xfer_to_host),
    .xfer_done(xfer_done), .busy(busy), .chain_end(chain_end)
  );

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !xfer_valid);
endmodule

// File: tb/sim_sgl_walker.sv
module sim_sgl_walker;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic xfer_valid, xfer_ready = 1'b0, xfer_to_host, xfer_done = 1'b0;
  logic [31:0] xfer_addr;
  logic [LEN_W-1:0] xfer_len;
  logic irq;

  always #10 clk = ~clk;

  sgl_walker #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .xfer_to_host(xfer_to_host), .xfer_done(xfer_done),
    .irq(irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [64];
  logic [31:0] f_log [16];
  int f_n = 0;
  logic [31:0] c_addr [8];
  logic [31:0] c_len [8];
  logic c_dir [8];
  int c_n = 0;
  int pend = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory and mover models, driven away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      mem_rdata = mem[mem_addr[7:2]];
      if (f_n < 16) f_log[f_n] = mem_addr;
      f_n++;
    end
    xfer_done = 1'b0;
    if (pend != 0) begin
      pend--;
      xfer_done = (pend == 0);
    end
    xfer_ready = (cyc % 3) != 0;
    if (xfer_valid && xfer_ready) begin
      if (c_n < 8) begin
        c_addr[c_n] = xfer_addr;
        c_len[c_n] = {16'h0, xfer_len};
        c_dir[c_n] = xfer_to_host;
      end
      c_n++;
      pend = 3;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int slot_base(input int i);
    return ((5 * i + 3) % 16) * 16;
  endfunction

  task automatic run_chain(input int n, input int dirs, input int zmask, input int ctl);
    logic [31:0] v;
    int exp_c;
    int guard;
    for (int k = 0; k < 64; k++) mem[k] = 32'hDEAD_0000 + k;
    for (int i = 0; i < n; i++) begin
      int b = slot_base(i);
      logic [31:0] lk;
      mem[b/4]     = 32'h1000_0000 + i * 32'h100 + n;
      mem[b/4 + 1] = zmask[i] ? 32'h0 : (i * 7 + n + 1);
      if (i == n - 1) lk = 32'hFFFF_FF00 | 32'h1;
      else lk = slot_base(i + 1) | 32'h4;
      if (i != n - 1 && (i % 2 == 1)) lk = lk | 32'h8;
      lk = lk | (dirs[i] ? 32'h2 : 32'h0);
      mem[b/4 + 2] = lk;
    end
    wr(2'd2, ctl);
    f_n = 0; c_n = 0;
    wr(2'd0, slot_base(0) | 32'h7);
    rd(2'd1, v);
    chk(v[0] == 1'b1, "R5 busy after start", v, 1);
    // write while busy: must be ignored (R6)
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_0040;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(2'd0, v);
    chk(v == slot_base(0), "R6 pointer kept while busy (R5 low bits zeroed)", v, slot_base(0));
    guard = 0;
    rd(2'd1, v);
    while (v[0] && guard < 500) begin
      @(negedge clk);
      rd(2'd1, v);
      guard++;
    end
    chk(guard < 500, "R3 chain ended", guard, 0);
    chk(v[1] == 1'b1, "R7 done set as busy falls", v, 2);
    chk(irq == (ctl[0] & ctl[1]), "R8 irq gating", irq, ctl[0] & ctl[1]);
    chk(f_n == 3 * n, "R1 fetch count", f_n, 3 * n);
    for (int i = 0; i < n && 3 * i + 2 < 16; i++)
      for (int w = 0; w < 3; w++)
        chk(f_log[3*i+w] == slot_base(i) + 4 * w, "R1/R3 fetch address",
            f_log[3*i+w], slot_base(i) + 4 * w);
    exp_c = 0;
    for (int i = 0; i < n; i++) if (!zmask[i]) begin
      chk(c_addr[exp_c] == 32'h1000_0000 + i * 32'h100 + n, "R2 cmd addr",
          c_addr[exp_c], 32'h1000_0000 + i * 32'h100 + n);
      chk(c_len[exp_c] == i * 7 + n + 1, "R2 cmd len", c_len[exp_c], i * 7 + n + 1);
      chk(c_dir[exp_c] == dirs[i], "R2 cmd direction", c_dir[exp_c], dirs[i]);
      exp_c++;
    end
    chk(c_n == exp_c, "R4 zero counts skipped / R9 one cmd each", c_n, exp_c);
    wr(2'd1, 32'h0);
    rd(2'd1, v);
    chk(v[1] == 1'b1, "R7 zero write keeps done", v, 2);
    wr(2'd1, 32'h2);
    rd(2'd1, v);
    chk(v[1:0] == 2'b00, "R7 write-one clears done", v, 0);
    chk(irq == 1'b0, "R8 irq low after clear", irq, 0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd1, v);
    chk(v == 0, "R10 status after reset", v, 0);
    rd(2'd2, v);
    chk(v == 0, "R10 control after reset", v, 0);
    rd(2'd3, v);
    chk(v == 0, "R8 index 3 reads zero", v, 0);
    chk(irq == 0 && mem_req == 0 && xfer_valid == 0, "R10 outputs idle",
        {irq, mem_req, xfer_valid}, 0);
    for (int n = 1; n <= 3; n++)
      for (int d = 0; d < (1 << n); d++)
        for (int z = 0; z < (1 << n); z++)
          run_chain(n, d, z, (d + z + n) % 4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule